// File: doc/BRIEF.md
# Synchronous Power-Down Clock Gater

This block sits between a set of free-running peripheral clocks and the loads they drive. It stops those clocks cleanly when an active-low power-down pin is asserted, and it lets configuration logic switch off any single output through its own enable bit. A clock that is stopped is always parked low. Its last high phase is always a full one, and the first high phase after a restart is also a full one, so no output ever produces a runt pulse.

The power-down pin is asynchronous. It is sampled on the rising edge of the CPU clock and is acted on only when two consecutive samples agree. This applies both when power-down is entered and when it is left. On entry, every gated output parks low at its next falling edge. A `core_stop` flag then tells the analog side that the oscillator and PLL may shut down. On exit, a settle counter stands in for oscillator and PLL start-up time. The outputs stay parked until that counter runs out.

Top module: `pd_clock_gater`

## Requirements
- R1: While the block is running and an output's enable bit is 1, that output follows its peripheral clock input.
- R2: Power-down is accepted only after `pwrdn_n` has been sampled 0 on two consecutive rising edges of `clk_cpu`. A low level seen at a single rising edge has no effect on any output or on `core_stop`.
- R3: After acceptance, each gated output goes low at the next falling edge of its own input and stays low. Every high pulse on any output lasts exactly one full high phase of its input.
- R4: An output whose enable bit (bit i of `clk_en` for output i) is 0 parks low in the same glitch-free way. Outputs whose enable bits are 1 are not affected.
- R5: `core_stop` rises one `clk_cpu` cycle after every gated output has parked while power-down is accepted. Whenever `core_stop` is 1, all gated outputs are 0.
- R6: Release is recognised only after `pwrdn_n` has been sampled 1 on two consecutive `clk_cpu` rising edges. `core_stop` falls one cycle after that.
- R7: After release is recognised, the outputs stay parked for SETTLE_CYC+1 `clk_cpu` cycles and then resume.
- R8: If power-down is accepted again while the settle count is still running, the block returns to the stopped state and `core_stop` rises again.
- R9: On reset, `core_stop` is 0, the block is running with the settle count already expired, and each output's gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU clock that samples the power-down pin and runs the control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| periph_clk | input | N_CLK | Free-running clocks to be gated |
| clk_en | input | N_CLK | Per-output enable bits from the configuration bank (1 = enabled) |
| gated_clk | output | N_CLK | Gated clock outputs, parked low when stopped |
| core_stop | output | 1 | All outputs parked under power-down; the analog core may shut down |

## Verification
The bench builds the block with three outputs and a settle count of 40 cycles. With a count that short, the whole stop, release, settle and resume sequence fits in about fifty CPU cycles, so many full power cycles can run, as can a re-entry in the middle of the settle period. The three peripheral clocks have half periods of 3, 4 and 7 ns against a 5 ns CPU clock. Their edges are offset from the CPU edges, so the gate flops see the stop request at many different phases. Every high pulse is measured against its input's high phase.

// File: rtl/pdcg_pkg.sv
package pdcg_pkg;
  typedef enum logic [1:0] {
    PD_RUN    = 2'd0,
    PD_STOP   = 2'd1,
    PD_SETTLE = 2'd2
  } pd_state_e;

  // width of a down-counter that must hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pdcg_req_filter.sv
module pdcg_req_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic low_twice,
  output logic high_twice
);
  logic smp_new, smp_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_new <= 1'b1;
      smp_old <= 1'b1;
    end else begin
      smp_new <= pin_n;
      smp_old <= smp_new;
    end
  end

  assign low_twice  = !smp_new && !smp_old;
  assign high_twice = smp_new && smp_old;
endmodule

// File: rtl/pdcg_settle_timer.sv
module pdcg_settle_timer #(
  parameter int CYC = 40,
  parameter int CW  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= CW'(CYC);
    else if (tick && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pdcg_gate_cell.sv
module pdcg_gate_cell (
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  output logic clk_o,
  output logic parked_o
);
  logic en_q;

  // enable moves only while the clock is low, so the AND cannot chop a phase
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_i;
  end

  assign clk_o    = clk_i & en_q;
  assign parked_o = !en_q;
endmodule

// File: rtl/pd_clock_gater.sv
module pd_clock_gater
  import pdcg_pkg::*;
#(
  parameter int N_CLK      = 4,
  parameter int SETTLE_CYC = 300000
) (
  input  logic             clk_cpu,
  input  logic             rst_n,
  input  logic             pwrdn_n,
  input  logic [N_CLK-1:0] periph_clk,
  input  logic [N_CLK-1:0] clk_en,
  output logic [N_CLK-1:0] gated_clk,
  output logic             core_stop
);
  localparam int CW = cnt_width(SETTLE_CYC);

  pd_state_e        state_q, state_d;
  logic             low_twice, high_twice;
  logic             settle_load, settle_done;
  logic             running, stopped, settling;
  logic             all_parked, core_stop_q;
  logic [N_CLK-1:0] gate_en, parked;

  pdcg_req_filter u_filt (
    .clk        (clk_cpu),
    .rst_n      (rst_n),
    .pin_n      (pwrdn_n),
    .low_twice  (low_twice),
    .high_twice (high_twice)
  );

  always_comb begin
    state_d     = state_q;
    settle_load = 1'b0;
    case (state_q)
      PD_RUN:    if (low_twice) state_d = PD_STOP;
      PD_STOP:   if (high_twice) begin
                   state_d     = PD_SETTLE;
                   settle_load = 1'b1;
                 end
      PD_SETTLE: if (low_twice)        state_d = PD_STOP;
                 else if (settle_done) state_d = PD_RUN;
      default:   state_d = PD_STOP;
    endcase
  end

  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n) state_q <= PD_RUN;
    else        state_q <= state_d;
  end

  assign running  = (state_q == PD_RUN);
  assign stopped  = (state_q == PD_STOP);
  assign settling = (state_q == PD_SETTLE);

  pdcg_settle_timer #(.CYC(SETTLE_CYC), .CW(CW)) u_tmr (
    .clk   (clk_cpu),
    .rst_n (rst_n),
    .load  (settle_load),
    .tick  (settling),
    .done  (settle_done)
  );

  assign gate_en = clk_en & {N_CLK{running}};

  for (genvar g = 0; g < N_CLK; g++) begin : g_gate
    pdcg_gate_cell u_cell (
      .clk_i    (periph_clk[g]),
      .rst_n    (rst_n),
      .en_i     (gate_en[g]),
      .clk_o    (gated_clk[g]),
      .parked_o (parked[g])
    );
  end

  assign all_parked = &parked;

  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n) core_stop_q <= 1'b0;
    else        core_stop_q <= stopped && all_parked;
  end

  assign core_stop = core_stop_q;
endmodule

// File: rtl/pdcg_checker.sv
module pdcg_checker #(
  parameter int N_CLK = 4
) (
  input logic             clk_cpu,
  input logic             rst_n,
  input logic             pwrdn_n,
  input logic [N_CLK-1:0] gated_clk,
  input logic             core_stop,
  input logic             stopped,
  input logic             settling,
  input logic             running
);
  a_r2_two_low_to_stop: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $rose(stopped) |-> (!$past(pwrdn_n, 1) && !$past(pwrdn_n, 2)));

  a_r5_core_stop_all_low: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    core_stop |-> (gated_clk == '0));

  a_r5_core_stop_after_stop: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $rose(core_stop) |-> $past(stopped));

  a_r6_two_high_to_release: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $fell(stopped) |-> ($past(pwrdn_n, 1) && $past(pwrdn_n, 2)));

  a_r7_run_only_after_settle: assert property (@(posedge clk_cpu) disable iff (!rst_n)
    $rose(running) |-> $past(settling));
endmodule

bind pd_clock_gater pdcg_checker #(.N_CLK(N_CLK)) u_chk (
  .clk_cpu   (clk_cpu),
  .rst_n     (rst_n),
  .pwrdn_n   (pwrdn_n),
  .gated_clk (gated_clk),
  .core_stop (core_stop),
  .stopped   (stopped),
  .settling  (settling),
  .running   (running)
);

// File: tb/pd_clock_gater_test.sv
`timescale 1ns/100ps
module pd_clock_gater_test;
  localparam int NC  = 3;
  localparam int SET = 40;
  localparam real PH  [NC] = '{3.0, 4.0, 7.0};
  localparam real OFS [NC] = '{0.3, 0.7, 1.1};

  logic          clk_cpu = 1'b0;
  logic          rst_n   = 1'b0;
  logic          pwrdn_n = 1'b1;
  logic [NC-1:0] pclk    = '0;
  logic [NC-1:0] en      = '1;
  logic [NC-1:0] gclk;
  logic          core_stop;

  int checks = 0, fails = 0;
  int edge_cnt [NC];
  int runt_bad [NC];
  bit done_flag = 0;

  pd_clock_gater #(.N_CLK(NC), .SETTLE_CYC(SET)) uut (
    .clk_cpu(clk_cpu), .rst_n(rst_n), .pwrdn_n(pwrdn_n),
    .periph_clk(pclk), .clk_en(en), .gated_clk(gclk), .core_stop(core_stop));

  always #2.5 clk_cpu = ~clk_cpu;

  for (genvar i = 0; i < NC; i++) begin : g_clk
    real tr;
    bit  have;
    initial begin
      have = 0;
      #(OFS[i]);
      forever #(PH[i]) pclk[i] = ~pclk[i];
    end
    always @(posedge gclk[i]) if (rst_n) begin
      edge_cnt[i] = edge_cnt[i] + 1;
      tr = $realtime;
      have = 1;
    end
    always @(negedge gclk[i]) if (rst_n && have) begin
      if (($realtime - tr) < PH[i] - 0.05 || ($realtime - tr) > PH[i] + 0.05) begin
        runt_bad[i] = runt_bad[i] + 1;
        $display("FAIL R3 pulse width out %0d: actual %0.2f expected %0.2f", i, $realtime - tr, PH[i]);
      end
    end
  end

  function automatic bit exp_toggle(input logic [NC-1:0] m, input int i, input bit stopped);
    return m[i] && !stopped;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_cpu);
  endtask

  // expected toggling per output over a window of several slow periods
  task automatic check_win(input bit stopped, input string tag);
    int snap [NC];
    for (int i = 0; i < NC; i++) snap[i] = edge_cnt[i];
    #80;
    for (int i = 0; i < NC; i++) begin
      bit exp = exp_toggle(en, i, stopped);
      bit tog = (edge_cnt[i] - snap[i]) > 0;
      check(tog == exp && (exp || gclk[i] == 1'b0), tag, int'(tog), int'(exp));
    end
  endtask

  task automatic full_cycle();
    pwrdn_n = 1'b0;
    cyc(12);
    check(core_stop == 1'b1, "R5 core_stop after park", core_stop, 1);
    check_win(1, "R3 all parked under power-down");
    pwrdn_n = 1'b1;
    cyc(1);
    check(core_stop == 1'b1, "R6 one high sample not enough", core_stop, 1);
    cyc(4);
    check(core_stop == 1'b0, "R6 core_stop released", core_stop, 0);
    check_win(1, "R7 parked during settle");
    cyc(SET + 10);
    check_win(0, "R7 resumed after settle");
  endtask

  initial begin
    void'($urandom(32'd12345));
    for (int i = 0; i < NC; i++) begin edge_cnt[i] = 0; runt_bad[i] = 0; end
    #20;
    @(negedge clk_cpu) rst_n = 1'b1;
    check(core_stop == 1'b0, "R9 core_stop after reset", core_stop, 0);
    cyc(2);
    check_win(0, "R9 R1 outputs running after reset");

    en = 3'b101; cyc(8);
    check_win(0, "R4 single output disabled");
    en = 3'b111; cyc(8);
    check_win(0, "R1 all outputs re-enabled");

    pwrdn_n = 1'b0; cyc(1); pwrdn_n = 1'b1;
    cyc(6);
    check(core_stop == 1'b0, "R2 single low sample ignored", core_stop, 0);
    check_win(0, "R2 outputs unaffected by glitch");

    full_cycle();

    // re-entry during settle
    pwrdn_n = 1'b0; cyc(12);
    pwrdn_n = 1'b1; cyc(12);
    check(core_stop == 1'b0, "R8 in settle", core_stop, 0);
    pwrdn_n = 1'b0; cyc(SET + 20);
    check(core_stop == 1'b1, "R8 stop again from settle", core_stop, 1);
    check_win(1, "R8 outputs stay parked");
    pwrdn_n = 1'b1; cyc(SET + 12);
    check_win(0, "R8 resume after final release");

    for (int it = 0; it < 30; it++) begin
      int mode = int'($urandom % 3);
      en = NC'($urandom % 8);
      cyc(8);
      if (mode == 1) begin
        pwrdn_n = 1'b0; cyc(1); pwrdn_n = 1'b1; cyc(6);
        check(core_stop == 1'b0, "R2 random glitch", core_stop, 0);
      end else if (mode == 2) begin
        pwrdn_n = 1'b0; cyc(12);
        check(core_stop == 1'b1, "R5 random stop", core_stop, 1);
        check_win(1, "R3 random stop parked");
        pwrdn_n = 1'b1; cyc(SET + 12);
      end
      check_win(0, "R4 R1 random mask");
    end

    for (int i = 0; i < NC; i++)
      check(runt_bad[i] == 0, "R3 no runt pulses", runt_bad[i], 0);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule